// File: doc/BRIEF.md
# Programming Supply Sequencer for a Nonvolatile Array

This block sits on a register bus next to a nonvolatile array. It decides when the high-voltage programming supply may be applied. To turn the supply on, software must complete an ordered handshake. First it writes a control register with the latch bit set and the program bit clear. Next it writes one data word to the array window or to the configuration address. Finally it writes the control register with both bits set. The block takes the address and data of that single data write and holds them as the target presented to the array.

Any shortcut is refused. This covers both bits arriving in one write, a missing data write, and stray addresses. Clearing the latch bit at any time removes the supply and returns the sequencer to its idle state. The control register can be read back at any time.

Top module: `eevpp_seq`

## Requirements
- R1: After reset, the latch bit, the program bit, `vpp_en`, `tgt_addr` and `tgt_data` are all 0.
- R2: When idle, a control write with the latch bit (bit 1) set and the program bit (bit 0) clear sets the latch bit only. `vpp_en` stays 0.
- R3: `vpp_en` rises one cycle after a control write with both bits set. This happens only when that write follows a latch-only control write and then a qualifying data write.
- R4: A control write that sets both bits while the latch bit is clear leaves both bits and `vpp_en` at 0.
- R5: A control write that sets both bits while latched but before any qualifying data write keeps the latch bit and leaves the program bit and `vpp_en` at 0.
- R6: A write to an address outside the array window, other than the configuration address, never advances the sequence and never changes the target outputs.
- R7: The first write to `[ARR_BASE, ARR_BASE+ARR_SIZE)` or to `CFG_ADDR` after latching is captured on `tgt_addr`/`tgt_data`. Later data writes leave the target unchanged until the sequence restarts.
- R8: A control write with the latch bit clear drops `vpp_en` and both bits in the next cycle, from any state.
- R9: With `bus_addr` equal to `CTL_ADDR`, `ctl_rdata` shows the latch bit at bit 1 and the program bit at bit 0, with all other bits 0. At any other address, `ctl_rdata` is 0.
- R10: A data write while idle is not captured. It also does not count as the data step of a later sequence.
- R11: A latch-only control write while the supply is on drops `vpp_en` and the program bit. A following control write with both bits set turns the supply back on without a new data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data |
| ctl_rdata | output | DATA_W | Control register read value (combinational) |
| ctl_latch | output | 1 | Current latch bit |
| ctl_prog | output | 1 | Current program bit |
| vpp_en | output | 1 | Programming supply enable |
| tgt_addr | output | ADDR_W | Captured array address |
| tgt_data | output | DATA_W | Captured array data |

## Verification
The bench targets the shortcuts around the handshake. It sets both bits in one write, which a faulty design would turn into an immediate supply enable. It sets both bits without the data step, which a faulty design would accept. It writes data while idle, which a faulty design would let pre-arm the sequence. It sends stray addresses, which a faulty design would capture.

It also checks the window edges one below and one at the top bound, where an off-by-one decode would arm the sequence. It checks that a second data write cannot overwrite the captured target. It checks that a latch-clear write tears the supply down, and that a latch-only write leaves the sequence armed.

// File: rtl/eevpp_pkg.sv
package eevpp_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LATCH = 2'd1,
      SQ_ARMED = 2'd2,
      SQ_PROG  = 2'd3
   } seq_state_t;
endpackage

// File: rtl/eevpp_decode.sv
module eevpp_decode #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h103B,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h103F,
   parameter logic [ADDR_W-1:0] ARR_BASE = 16'hB600,
   parameter int unsigned ARR_SIZE = 512
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ctl_hit,
   output logic              cfg_hit,
   output logic              arr_hit
);
   localparam bit SIZE_POW2 = ((ARR_SIZE & (ARR_SIZE - 1)) == 0);

   assign ctl_hit = (addr == CTL_ADDR);
   assign cfg_hit = (addr == CFG_ADDR);

   generate
      if (SIZE_POW2) begin : g_mask
         // aligned power-of-two window: one masked compare
         localparam logic [ADDR_W-1:0] MASK = ADDR_W'(ARR_SIZE - 1);
         assign arr_hit = ((addr & ~MASK) == (ARR_BASE & ~MASK));
      end else begin : g_range
         localparam logic [ADDR_W:0] LO = {1'b0, ARR_BASE};
         localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(ARR_SIZE);
         logic [ADDR_W:0] ext;
         assign ext     = {1'b0, addr};
         assign arr_hit = (ext >= LO) && (ext < HI);
      end
   endgenerate
endmodule

// File: rtl/eevpp_fsm.sv
module eevpp_fsm
   import eevpp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       data_wr,
   input  logic       wr_lat,
   input  logic       wr_pgm,
   output logic       lat_q,
   output logic       pgm_q,
   output logic       vpp_q,
   output logic       capture
);
   seq_state_t st, nxt;

   always_comb begin
      nxt     = st;
      capture = 1'b0;
      if (ctl_wr) begin
         if (!wr_lat) begin
            nxt = SQ_IDLE;
         end else begin
            unique case (st)
               SQ_IDLE:  nxt = wr_pgm ? SQ_IDLE  : SQ_LATCH;
               SQ_LATCH: nxt = SQ_LATCH;
               SQ_ARMED: nxt = wr_pgm ? SQ_PROG  : SQ_ARMED;
               SQ_PROG:  nxt = wr_pgm ? SQ_PROG  : SQ_ARMED;
               default:  nxt = SQ_IDLE;
            endcase
         end
      end else if (data_wr && st == SQ_LATCH) begin
         nxt     = SQ_ARMED;
         capture = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= SQ_IDLE;
         vpp_q <= 1'b0;
      end else begin
         st    <= nxt;
         vpp_q <= (nxt == SQ_PROG);
      end
   end

   assign lat_q = (st != SQ_IDLE);
   assign pgm_q = (st == SQ_PROG);
endmodule

// File: rtl/eevpp_capture.sv
module eevpp_capture #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_addr <= '0;
         out_data <= '0;
      end else if (load) begin
         out_addr <= in_addr;
         out_data <= in_data;
      end
   end
endmodule

// File: rtl/eevpp_seq.sv
module eevpp_seq #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h103B,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h103F,
   parameter logic [ADDR_W-1:0] ARR_BASE = 16'hB600,
   parameter int unsigned ARR_SIZE = 512,
   parameter int unsigned LAT_BIT  = 1,
   parameter int unsigned PGM_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] ctl_rdata,
   output logic              ctl_latch,
   output logic              ctl_prog,
   output logic              vpp_en,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data
);
   generate
      if (LAT_BIT >= DATA_W || PGM_BIT >= DATA_W || LAT_BIT == PGM_BIT) begin : g_bad_bits
         $error("eevpp_seq: control bit positions invalid");
      end
      if (ARR_SIZE == 0) begin : g_bad_size
         $error("eevpp_seq: empty array window");
      end
   endgenerate

   logic ctl_hit, cfg_hit, arr_hit;
   logic ctl_wr, data_wr, capture;

   eevpp_decode #(
      .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .CFG_ADDR(CFG_ADDR),
      .ARR_BASE(ARR_BASE), .ARR_SIZE(ARR_SIZE)
   ) u_dec (
      .addr(bus_addr), .ctl_hit(ctl_hit), .cfg_hit(cfg_hit), .arr_hit(arr_hit)
   );

   assign ctl_wr  = bus_wr & ctl_hit;
   assign data_wr = bus_wr & (arr_hit | cfg_hit) & ~ctl_hit;

   eevpp_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr),
      .wr_lat(bus_wdata[LAT_BIT]), .wr_pgm(bus_wdata[PGM_BIT]),
      .lat_q(ctl_latch), .pgm_q(ctl_prog), .vpp_q(vpp_en), .capture(capture)
   );

   eevpp_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(capture),
      .in_addr(bus_addr), .in_data(bus_wdata),
      .out_addr(tgt_addr), .out_data(tgt_data)
   );

   always_comb begin
      ctl_rdata = '0;
      if (ctl_hit) begin
         ctl_rdata[LAT_BIT] = ctl_latch;
         ctl_rdata[PGM_BIT] = ctl_prog;
      end
   end
endmodule

// File: rtl/eevpp_seq_chk.sv
module eevpp_seq_chk #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h103B,
   parameter int unsigned LAT_BIT  = 1,
   parameter int unsigned PGM_BIT  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              ctl_latch,
   input logic              ctl_prog,
   input logic              vpp_en
);
   logic cw;
   assign cw = bus_wr && (bus_addr == CTL_ADDR);

   AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> !vpp_en && !ctl_latch && !ctl_prog); // R1
   AST_VPP_NEEDS_PGM: assert property (@(posedge clk) disable iff (!rst_n) vpp_en |-> ctl_prog && ctl_latch); // R3
   AST_VPP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vpp_en) |-> $past(cw && bus_wdata[LAT_BIT] && bus_wdata[PGM_BIT])); // R3
   AST_BOTH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cw && !ctl_latch && bus_wdata[LAT_BIT] && bus_wdata[PGM_BIT] |=> !ctl_latch && !ctl_prog && !vpp_en); // R4
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      cw && !bus_wdata[LAT_BIT] |=> !vpp_en && !ctl_latch && !ctl_prog); // R8
   AST_STRAY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_latch && !cw |=> !ctl_latch); // R6
endmodule

bind eevpp_seq eevpp_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
   .LAT_BIT(LAT_BIT), .PGM_BIT(PGM_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ctl_latch(ctl_latch), .ctl_prog(ctl_prog),
   .vpp_en(vpp_en)
);

// File: tb/tb_eevpp_seq.sv
module tb_eevpp_seq;
   localparam logic [15:0] CTL = 16'h103B;
   localparam logic [15:0] CFG = 16'h103F;
   localparam logic [15:0] BASE = 16'hB600;
   localparam logic [15:0] LAST = 16'hB7FF;
   localparam logic [7:0] LAT_ONLY = 8'h02;
   localparam logic [7:0] BOTH = 8'h03;
   localparam logic [7:0] NONE = 8'h00;

   logic clk = 0, rst_n = 0, bus_wr = 0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic ctl_latch, ctl_prog, vpp_en;
   logic [15:0] tgt_addr;
   logic [7:0]  tgt_data;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   eevpp_seq dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .ctl_rdata(ctl_rdata), .ctl_latch(ctl_latch),
      .ctl_prog(ctl_prog), .vpp_en(vpp_en), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 latch", ctl_latch, 0);
      chk("R1 prog", ctl_prog, 0);
      chk("R1 vpp", vpp_en, 0);
      chk("R1 tgt", {tgt_addr, tgt_data}, 0);
   endtask

   task automatic t_full_seq();
      do_reset();
      wr(CTL, LAT_ONLY);
      chk("R2 latch", ctl_latch, 1);
      chk("R2 vpp", vpp_en, 0);
      wr(BASE + 16'h10, 8'hA5);
      chk("R7 addr", tgt_addr, BASE + 16'h10);
      chk("R7 data", tgt_data, 8'hA5);
      chk("R3 vpp before final", vpp_en, 0);
      wr(CTL, BOTH);
      chk("R3 vpp", vpp_en, 1);
      chk("R3 prog", ctl_prog, 1);
      wr(LAST, 8'h11);
      chk("R7 no overwrite", {tgt_addr, tgt_data}, {BASE + 16'h10, 8'hA5});
      wr(CTL, LAT_ONLY);
      chk("R11 vpp drop", vpp_en, 0);
      chk("R11 prog drop", ctl_prog, 0);
      chk("R11 latch kept", ctl_latch, 1);
      wr(CTL, BOTH);
      chk("R11 re-enable", vpp_en, 1);
      wr(CTL, NONE);
      chk("R8 vpp", vpp_en, 0);
      chk("R8 bits", {ctl_latch, ctl_prog}, 0);
   endtask

   task automatic t_both_at_once();
      do_reset();
      wr(CTL, BOTH);
      chk("R4 bits", {ctl_latch, ctl_prog}, 0);
      chk("R4 vpp", vpp_en, 0);
   endtask

   task automatic t_skip_data();
      do_reset();
      wr(CTL, LAT_ONLY);
      wr(CTL, BOTH);
      chk("R5 latch", ctl_latch, 1);
      chk("R5 prog", ctl_prog, 0);
      chk("R5 vpp", vpp_en, 0);
   endtask

   task automatic t_stray();
      do_reset();
      wr(CTL, LAT_ONLY);
      wr(BASE - 16'h1, 8'h5A);
      wr(LAST + 16'h1, 8'h5B);
      wr(16'h1000, 8'h5C);
      chk("R6 tgt", {tgt_addr, tgt_data}, 0);
      wr(CTL, BOTH);
      chk("R6 vpp", vpp_en, 0);
      wr(LAST, 8'h77);
      chk("R7 top edge", {tgt_addr, tgt_data}, {LAST, 8'h77});
   endtask

   task automatic t_cfg_and_idle();
      do_reset();
      wr(BASE, 8'h33);
      chk("R10 tgt", {tgt_addr, tgt_data}, 0);
      wr(CTL, LAT_ONLY);
      wr(CTL, BOTH);
      chk("R10 vpp", vpp_en, 0);
      wr(CFG, 8'h0F);
      chk("R7 cfg", {tgt_addr, tgt_data}, {CFG, 8'h0F});
      wr(CTL, BOTH);
      chk("R3 via cfg", vpp_en, 1);
   endtask

   task automatic t_readback();
      do_reset();
      wr(CTL, LAT_ONLY);
      wr(BASE, 8'h01);
      wr(CTL, BOTH);
      @(negedge clk); bus_addr = CTL; #1;
      chk("R9 both", ctl_rdata, 8'h03);
      bus_addr = BASE; #1;
      chk("R9 other addr", ctl_rdata, 8'h00);
      bus_addr = '0;
      wr(CTL, LAT_ONLY);
      @(negedge clk); bus_addr = CTL; #1;
      chk("R9 latch only", ctl_rdata, 8'h02);
      bus_addr = '0;
   endtask

   initial begin
      t_reset();
      t_full_seq();
      t_both_at_once();
      t_skip_data();
      t_stray();
      t_cfg_and_idle();
      t_readback();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule